// File: doc/BRIEF.md
# Variable-Page Translation Lookup Engine

This block searches a small fully associative table of address translations. Software or a refill agent loads the table through a single write port. Each slot holds a tag word, a data word and an 8-bit owner tag. A lookup is started with a virtual address, an access kind (read, write or fetch), a user/supervisor flag, the current 8-bit process number and a 32-bit zone protection word. The engine then walks the slots from index 0 upward, one slot per clock. It reports a hit, a protection fault or a miss, together with the deciding index, the physical page base and the page-size code.

Each slot chooses its own page size from eight sizes, from 1 KB up to 16 MB. A slot can be private to one process or shared by all processes. A 4-bit zone selector in the data word picks a 2-bit code from the zone protection word. That code can hide the slot from user accesses or widen its write and execute rights.

Top module: `tlb_scan_engine`

## Requirements
- R1: After reset every slot is invalid and the outputs are busy=0, done=0, status=00, hit_idx=0, pa=0, page_code=0. A write-port strobe stores wr_tag, wr_data and wr_tid into slot wr_idx at the clock edge.
- R2: The tag word carries the page number in bits 31:10 and a size code in bits 9:7. Code c selects a page of 1 KB shifted left by 2c (codes 0..7 give 1K, 4K, 16K, 64K, 256K, 1M, 4M, 16M). A slot's address matches when the virtual address and the tag agree in every bit at or above log2 of the page size.
- R3: A slot takes part in the search only while tag bit 6 (valid) is 1.
- R4: A slot whose owner tag is nonzero matches only when the owner tag equals pid. An owner tag of 0 matches every pid.
- R5: Slots are evaluated in rising index order, and the first slot that matches and is not skipped decides the result.
- R6: The zone selector z is data bits 7:4. It picks the code zpr[31-2z:30-2z]. Code 0 skips the slot for user accesses and leaves supervisor accesses to the slot's own rights. Code 1 keeps the slot's rights. Code 2 grants write and execute to supervisor accesses only. Code 3 grants both to every access.
- R7: When z is greater than ZONE_COUNT, or when ZONES_ON is 0, the code is taken as 1.
- R8: The access kind is acc=0 read, 1 write, 2 fetch. A read is always allowed on a match. A write needs data bit 8 (write right) and a fetch needs data bit 9 (execute right). A denied access ends the search with status 01 and hit_idx set to that slot, while pa=0 and page_code=0.
- R9: When no slot decides the search, status is 00 and hit_idx, pa and page_code are 0.
- R10: A hit gives status 10, the slot index, pa equal to data bits 31:10 (low 10 bits zero) ANDed with ADDR_MASK, and the slot's size code.
- R11: A start is taken only while busy is 0. The slot at index k is judged k+1 clocks after the start edge. done is a one-cycle pulse in the cycle after the deciding clock, busy falls together with it, and the results hold until the next done. A start while busy is ignored.
- R12: A write in the same cycle in which a slot is judged does not affect that judgement. Slots judged later see the new contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write-port strobe |
| wr_idx | input | $clog2(ENTRIES) | Slot to load |
| wr_tag | input | 32 | Tag word: page number, size code, valid |
| wr_data | input | 32 | Data word: physical page, execute, write, zone selector |
| wr_tid | input | 8 | Owner tag, 0 = shared |
| start | input | 1 | Begin a lookup |
| va | input | 32 | Virtual address |
| acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| user | input | 1 | 1 = user access, 0 = supervisor |
| pid | input | 8 | Current process number |
| zpr | input | 32 | Zone protection word |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| status | output | 2 | 00 miss, 01 protection fault, 10 hit |
| hit_idx | output | $clog2(ENTRIES) | Deciding slot |
| pa | output | 32 | Physical page base on a hit |
| page_code | output | 3 | Size code of the hit slot |

## Verification
Two functions can fall in the same cycle: the write port updating a slot and the scan judging that same slot. The bench drives an invalidating write to slot 0 on the very clock at which slot 0 is judged. It expects the old contents to produce the hit, and it expects a second lookup to miss. It also pulses start in the middle of a scan and expects the first result to stand, with no second scan following. A behavioural model is compared every clock through these overlaps.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int WORD_W      = 32;
    localparam int VALID_BIT   = 6;
    localparam int SIZE_LO     = 7;
    localparam int PN_LO       = 10;
    localparam int WR_BIT      = 8;
    localparam int EX_BIT      = 9;
    localparam int ZSEL_LO     = 4;

    typedef enum logic [1:0] {
        ST_MISS  = 2'b00,
        ST_FAULT = 2'b01,
        ST_HIT   = 2'b10
    } tlb_status_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } tlb_acc_e;

    typedef enum logic [1:0] {
        V_PASS  = 2'd0,
        V_HIT   = 2'd1,
        V_FAULT = 2'd2
    } tlb_verdict_e;

    typedef struct packed {
        logic [WORD_W-1:0] tag;
        logic [WORD_W-1:0] data;
        logic [7:0]        tid;
    } tlb_slot_t;

    typedef struct packed {
        logic [WORD_W-1:0] va;
        logic [1:0]        acc;
        logic              user;
        logic [7:0]        pid;
        logic [WORD_W-1:0] zpr;
    } tlb_query_t;

    // Keeps the address bits at and above the page boundary of size code c.
    function automatic logic [WORD_W-1:0] page_keep_mask(input logic [2:0] c);
        logic [4:0] sh;
        sh = 5'd10 + {1'b0, c, 1'b0};
        return ~((32'd1 << sh) - 32'd1);
    endfunction

    // Zone z owns two bits counted from the most significant end.
    function automatic logic [1:0] zone_code(input logic [WORD_W-1:0] zw,
                                             input logic [3:0] z);
        logic [4:0] sh;
        sh = 5'd30 - {z, 1'b0};
        return zw[sh +: 2];
    endfunction

endpackage

// File: rtl/tlb_slot_store.sv
module tlb_slot_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_slot_t        wr_slot,
    input  logic [IDX_W-1:0] rd_idx,
    output tlb_slot_t        rd_slot
);

    tlb_slot_t mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_slot;
        end
    end

    assign rd_slot = mem[rd_idx];

endmodule

// File: rtl/tlb_slot_judge.sv
module tlb_slot_judge
    import tlb_pkg::*;
#(
    parameter int              ZONE_COUNT = 8,
    parameter bit              ZONES_ON   = 1'b1,
    parameter logic [31:0]     ADDR_MASK  = 32'hFFFF_FFFF
) (
    input  tlb_slot_t    slot,
    input  tlb_query_t   q,
    output tlb_verdict_e verdict,
    output logic [31:0]  phys,
    output logic [2:0]   code
);

    localparam logic [4:0] ZLIM = 5'(ZONE_COUNT);

    logic       present, addr_eq, owner_ok;
    logic [3:0] zsel;
    logic [1:0] zc;
    logic       may_wr, may_ex, hide;

    assign code     = slot.tag[SIZE_LO +: 3];
    assign present  = slot.tag[VALID_BIT];
    assign addr_eq  = ((q.va ^ slot.tag) & page_keep_mask(code)) == '0;
    assign owner_ok = (slot.tid == 8'd0) || (slot.tid == q.pid);
    assign zsel     = slot.data[ZSEL_LO +: 4];
    assign phys     = slot.data & {{(WORD_W-PN_LO){1'b1}}, {PN_LO{1'b0}}} & ADDR_MASK;

    generate
        if (ZONES_ON) begin : g_zones
            assign zc = ({1'b0, zsel} > ZLIM) ? 2'd1 : zone_code(q.zpr, zsel);
        end else begin : g_flat
            assign zc = 2'd1;
        end
    endgenerate

    always_comb begin
        may_wr = slot.data[WR_BIT];
        may_ex = slot.data[EX_BIT];
        hide   = 1'b0;
        case (zc)
            2'd0: hide = q.user;
            2'd2: if (!q.user) begin
                      may_wr = 1'b1;
                      may_ex = 1'b1;
                  end
            2'd3: begin
                      may_wr = 1'b1;
                      may_ex = 1'b1;
                  end
            default: ;
        endcase

        if (!(present && addr_eq && owner_ok) || hide) begin
            verdict = V_PASS;
        end else if ((q.acc == ACC_WRITE && !may_wr) ||
                     (q.acc == ACC_FETCH && !may_ex)) begin
            verdict = V_FAULT;
        end else begin
            verdict = V_HIT;
        end
    end

endmodule

// File: rtl/tlb_scan_ctrl.sv
module tlb_scan_ctrl
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  tlb_query_t       q_in,
    output tlb_query_t       q_hold,
    output logic [IDX_W-1:0] scan_idx,
    input  tlb_verdict_e     verdict,
    input  logic [31:0]      phys,
    input  logic [2:0]       code,
    output logic             busy,
    output logic             done,
    output tlb_status_e      status,
    output logic [IDX_W-1:0] hit_idx,
    output logic [31:0]      pa,
    output logic [2:0]       page_code
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_hold    <= '0;
            scan_idx  <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
            status    <= ST_MISS;
            hit_idx   <= '0;
            pa        <= '0;
            page_code <= '0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (verdict != V_PASS) begin
                    busy      <= 1'b0;
                    done      <= 1'b1;
                    hit_idx   <= scan_idx;
                    status    <= (verdict == V_HIT) ? ST_HIT : ST_FAULT;
                    pa        <= (verdict == V_HIT) ? phys : '0;
                    page_code <= (verdict == V_HIT) ? code : '0;
                end else if (scan_idx == LAST) begin
                    busy      <= 1'b0;
                    done      <= 1'b1;
                    hit_idx   <= '0;
                    status    <= ST_MISS;
                    pa        <= '0;
                    page_code <= '0;
                end else begin
                    scan_idx <= scan_idx + 1'b1;
                end
            end else if (start) begin
                busy     <= 1'b1;
                scan_idx <= '0;
                q_hold   <= q_in;
            end
        end
    end

endmodule

// File: rtl/tlb_scan_engine.sv
module tlb_scan_engine
    import tlb_pkg::*;
#(
    parameter int          ENTRIES    = 8,
    parameter int          ZONE_COUNT = 8,
    parameter bit          ZONES_ON   = 1'b1,
    parameter logic [31:0] ADDR_MASK  = 32'hFFFF_FFFF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [$clog2(ENTRIES)-1:0] wr_idx,
    input  logic [31:0]                wr_tag,
    input  logic [31:0]                wr_data,
    input  logic [7:0]                 wr_tid,
    input  logic                       start,
    input  logic [31:0]                va,
    input  logic [1:0]                 acc,
    input  logic                       user,
    input  logic [7:0]                 pid,
    input  logic [31:0]                zpr,
    output logic                       busy,
    output logic                       done,
    output logic [1:0]                 status,
    output logic [$clog2(ENTRIES)-1:0] hit_idx,
    output logic [31:0]                pa,
    output logic [2:0]                 page_code
);

    localparam int IDX_W = $clog2(ENTRIES);

    tlb_slot_t        wslot, cur_slot;
    tlb_query_t       qin, qh;
    logic [IDX_W-1:0] sidx;
    tlb_verdict_e     verdict;
    logic [31:0]      phys;
    logic [2:0]       code;
    tlb_status_e      st;

    assign wslot = '{tag: wr_tag, data: wr_data, tid: wr_tid};
    assign qin   = '{va: va, acc: acc, user: user, pid: pid, zpr: zpr};

    tlb_slot_store #(.ENTRIES(ENTRIES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_slot (wslot),
        .rd_idx  (sidx),
        .rd_slot (cur_slot)
    );

    tlb_slot_judge #(
        .ZONE_COUNT (ZONE_COUNT),
        .ZONES_ON   (ZONES_ON),
        .ADDR_MASK  (ADDR_MASK)
    ) u_judge (
        .slot    (cur_slot),
        .q       (qh),
        .verdict (verdict),
        .phys    (phys),
        .code    (code)
    );

    tlb_scan_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .q_in      (qin),
        .q_hold    (qh),
        .scan_idx  (sidx),
        .verdict   (verdict),
        .phys      (phys),
        .code      (code),
        .busy      (busy),
        .done      (done),
        .status    (st),
        .hit_idx   (hit_idx),
        .pa        (pa),
        .page_code (page_code)
    );

    assign status = st;

endmodule

// File: rtl/tlb_scan_checker.sv
module tlb_scan_checker #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [1:0]       status,
    input logic [IDX_W-1:0] hit_idx,
    input logic [31:0]      pa,
    input logic [2:0]       page_code
);

    // R11: done lasts one cycle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: busy has fallen when done is shown
    p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));

    // R11: a scan only begins from a start request
    p_busy_from_start_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R11: results only move together with done
    p_result_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(status) && $stable(hit_idx) && $stable(pa)));

    // R9: a miss carries no index, page base or size
    p_miss_clean_r9: assert property (@(posedge clk) disable iff (rst)
        (done && status == 2'b00) |-> (hit_idx == '0 && pa == '0 && page_code == '0));

    // R8: a fault reports no page base
    p_fault_clean_r8: assert property (@(posedge clk) disable iff (rst)
        (done && status == 2'b01) |-> (pa == '0 && page_code == '0));

    // R10: status code 11 never appears
    p_status_legal_r10: assert property (@(posedge clk) disable iff (rst)
        status != 2'b11);

endmodule

bind tlb_scan_engine tlb_scan_checker #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .status    (status),
    .hit_idx   (hit_idx),
    .pa        (pa),
    .page_code (page_code)
);

// File: tb/tb_tlb_scan_engine.sv
`timescale 1ns/1ps
module tb_tlb_scan_engine;

    localparam int          N     = 8;
    localparam int          ZCNT  = 8;
    localparam logic [31:0] AMASK = 32'h3FFF_FFFF;
    localparam logic [31:0] ZW    = 32'h1B00_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_tag = '0, wr_data = '0;
    logic [7:0]  wr_tid = '0;
    logic        start = 1'b0;
    logic [31:0] va = '0;
    logic [1:0]  acc = '0;
    logic        user = 1'b0;
    logic [7:0]  pid = '0;
    logic [31:0] zpr = ZW;

    logic        busy, done, nz_busy, nz_done;
    logic [1:0]  status, nz_status;
    logic [2:0]  hit_idx, nz_idx, page_code, nz_code;
    logic [31:0] pa, nz_pa;

    int vecs = 0;
    int errs = 0;
    int cyc  = 0;

    always #5 clk = ~clk;

    tlb_scan_engine #(.ENTRIES(N), .ZONE_COUNT(ZCNT), .ZONES_ON(1'b1), .ADDR_MASK(AMASK)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
        .wr_data(wr_data), .wr_tid(wr_tid), .start(start), .va(va), .acc(acc),
        .user(user), .pid(pid), .zpr(zpr), .busy(busy), .done(done),
        .status(status), .hit_idx(hit_idx), .pa(pa), .page_code(page_code));

    tlb_scan_engine #(.ENTRIES(N), .ZONE_COUNT(ZCNT), .ZONES_ON(1'b0), .ADDR_MASK(AMASK)) dut_nz (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
        .wr_data(wr_data), .wr_tid(wr_tid), .start(start), .va(va), .acc(acc),
        .user(user), .pid(pid), .zpr(zpr), .busy(nz_busy), .done(nz_done),
        .status(nz_status), .hit_idx(nz_idx), .pa(nz_pa), .page_code(nz_code));

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        vecs++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_tag [N];
    logic [31:0] m_data[N];
    logic [7:0]  m_tid [N];
    bit          m_busy, m_done;
    int          m_idx;
    logic [1:0]  m_st;
    int          m_hidx;
    logic [31:0] m_pa;
    int          m_code;
    logic [31:0] q_va, q_zpr;
    int          q_acc;
    bit          q_user;
    logic [7:0]  q_pid;

    // 0 = keep searching, 1 = hit, 2 = fault
    function automatic int judge(input int i, output logic [31:0] p, output int c);
        longint bytes;
        int z, zc;
        bit w, x, skip;
        c = int'(m_tag[i][9:7]);
        p = (m_data[i] & 32'hFFFF_FC00) & AMASK;
        bytes = longint'(1024) << (2 * c);
        if (!m_tag[i][6]) return 0;
        if ((longint'(q_va) / bytes) != (longint'(m_tag[i]) / bytes)) return 0;
        if (m_tid[i] != 0 && m_tid[i] != q_pid) return 0;
        z  = int'(m_data[i][7:4]);
        zc = (z > ZCNT) ? 1 : int'((q_zpr >> (30 - 2 * z)) & 32'd3);
        w = m_data[i][8];
        x = m_data[i][9];
        skip = 0;
        if (zc == 0 && q_user) skip = 1;
        if (zc == 3 || (zc == 2 && !q_user)) begin w = 1; x = 1; end
        if (skip) return 0;
        if ((q_acc == 1 && !w) || (q_acc == 2 && !x)) return 2;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_tag[i] = '0; m_data[i] = '0; m_tid[i] = '0;
            end
            m_busy = 0; m_done = 0; m_idx = 0;
            m_st = 2'b00; m_hidx = 0; m_pa = '0; m_code = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                logic [31:0] p;
                int c, v;
                v = judge(m_idx, p, c);
                if (v != 0) begin
                    m_busy = 0; m_done = 1; m_hidx = m_idx;
                    m_st   = (v == 1) ? 2'b10 : 2'b01;
                    m_pa   = (v == 1) ? p : '0;
                    m_code = (v == 1) ? c : 0;
                end else if (m_idx == N - 1) begin
                    m_busy = 0; m_done = 1; m_hidx = 0;
                    m_st = 2'b00; m_pa = '0; m_code = 0;
                end else begin
                    m_idx++;
                end
            end else if (start) begin
                m_busy = 1; m_idx = 0;
                q_va = va; q_acc = int'(acc); q_user = user; q_pid = pid; q_zpr = zpr;
            end
            if (wr_en) begin
                m_tag[wr_idx] = wr_tag; m_data[wr_idx] = wr_data; m_tid[wr_idx] = wr_tid;
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            chk("R11", "busy",    32'(busy),      32'(m_busy));
            chk("R11", "done",    32'(done),      32'(m_done));
            chk("R10", "status",  32'(status),    32'(m_st));
            chk("R10", "hit_idx", 32'(hit_idx),   32'(m_hidx));
            chk("R10", "pa",      pa,             m_pa);
            chk("R10", "code",    32'(page_code), 32'(m_code));
        end
        if (cyc > 20000) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic load(input int i, input logic [31:0] t, input logic [31:0] d, input logic [7:0] o);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'(i); wr_tag = t; wr_data = d; wr_tid = o;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] a, input logic [1:0] k, input logic u,
                          input logic [7:0] p, output int lat);
        @(negedge clk);
        start = 1'b1; va = a; acc = k; user = u; pid = p;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!done && lat < 64);
    endtask

    task automatic expect_res(input string req, input logic [1:0] st, input int idx,
                              input logic [31:0] p, input int c);
        chk(req, "status",  32'(status),    32'(st));
        chk(req, "hit_idx", 32'(hit_idx),   32'(idx));
        chk(req, "pa",      pa,             p);
        chk(req, "code",    32'(page_code), 32'(c));
    endtask

    initial begin
        int lat;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "busy",   32'(busy),   0);
        chk("R1", "done",   32'(done),   0);
        chk("R1", "status", 32'(status), 0);
        chk("R1", "pa",     pa,          0);
        // R1/R9/R11: empty table misses after a full walk
        lookup(32'h0001_2345, 2'd0, 1'b1, 8'd5, lat);
        expect_res("R9", 2'b00, 0, 32'h0, 0);
        chk("R11", "miss latency", 32'(lat), N);

        load(0, 32'h0001_0140, 32'h8123_4010, 8'd5);
        load(1, 32'h0002_0440, 32'h9000_0520, 8'd0);
        load(2, 32'h0300_03C0, 32'hA000_0030, 8'd0);
        load(3, 32'h0004_00C0, 32'hB000_0090, 8'd0);
        load(4, 32'h0005_0080, 32'hE000_0300, 8'd0);
        load(5, 32'h0005_00C0, 32'hC0A0_0300, 8'd0);
        load(6, 32'h0005_00C0, 32'hD0B0_0310, 8'd0);

        // R2/R4/R10: 16 KB private page, owner matches
        lookup(32'h0001_2345, 2'd0, 1'b1, 8'd5, lat);
        expect_res("R10", 2'b10, 0, 32'h0123_4000, 2);
        chk("R11", "hit latency slot0", 32'(lat), 1);
        // R4: other owner skipped
        lookup(32'h0001_2345, 2'd0, 1'b1, 8'd6, lat);
        expect_res("R4", 2'b00, 0, 32'h0, 0);
        // R8: write without write right
        lookup(32'h0001_2345, 2'd1, 1'b1, 8'd5, lat);
        expect_res("R8", 2'b01, 0, 32'h0, 0);
        // R2: 1 KB page edges
        lookup(32'h0002_07FF, 2'd1, 1'b0, 8'd0, lat);
        expect_res("R2", 2'b10, 1, 32'h1000_0400, 0);
        lookup(32'h0002_0800, 2'd1, 1'b0, 8'd0, lat);
        expect_res("R2", 2'b00, 0, 32'h0, 0);
        // R6: zone code 2 widens supervisor only
        lookup(32'h0002_0500, 2'd2, 1'b0, 8'd0, lat);
        expect_res("R6", 2'b10, 1, 32'h1000_0400, 0);
        lookup(32'h0002_0500, 2'd2, 1'b1, 8'd0, lat);
        expect_res("R6", 2'b01, 1, 32'h0, 0);
        // R6/R2: zone code 3, 16 MB page
        lookup(32'h03FF_FFFF, 2'd1, 1'b1, 8'd0, lat);
        expect_res("R6", 2'b10, 2, 32'h2000_0000, 7);
        lookup(32'h0400_0000, 2'd1, 1'b1, 8'd0, lat);
        expect_res("R2", 2'b00, 0, 32'h0, 0);
        // R7: selector 9 above zone count acts as code 1
        lookup(32'h0004_0010, 2'd1, 1'b1, 8'd0, lat);
        expect_res("R7", 2'b01, 3, 32'h0, 0);
        lookup(32'h0004_0010, 2'd0, 1'b1, 8'd0, lat);
        expect_res("R7", 2'b10, 3, 32'h3000_0000, 1);
        // R3/R5/R6: invalid slot 4 ignored, code 0 hides slot 5 from user
        lookup(32'h0005_0010, 2'd0, 1'b1, 8'd0, lat);
        expect_res("R5", 2'b10, 6, 32'h10B0_0000, 1);
        chk("R11", "hit latency slot6", 32'(lat), 7);
        // R7: zones disabled lets slot 5 decide
        chk("R7", "nz status",  32'(nz_status), 2);
        chk("R7", "nz hit_idx", 32'(nz_idx),    5);
        chk("R7", "nz pa",      nz_pa,          32'h00A0_0000);
        // R5: supervisor takes first match, slot 5
        lookup(32'h0005_0010, 2'd0, 1'b0, 8'd0, lat);
        expect_res("R5", 2'b10, 5, 32'h00A0_0000, 1);

        // R11: start while busy is ignored
        @(negedge clk);
        start = 1'b1; va = 32'h0005_0010; acc = 2'd0; user = 1'b1; pid = 8'd0;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1; va = 32'h0001_2345; pid = 8'd5;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!done && lat < 64);
        expect_res("R11", 2'b10, 6, 32'h10B0_0000, 1);
        @(negedge clk);
        chk("R11", "no queued scan", 32'(busy), 0);

        // R12: invalidate slot 0 in the cycle it is judged
        @(negedge clk);
        start = 1'b1; va = 32'h0001_2345; acc = 2'd0; user = 1'b1; pid = 8'd5;
        @(negedge clk);
        start = 1'b0;
        wr_en = 1'b1; wr_idx = 3'd0; wr_tag = 32'h0001_0100; wr_data = 32'h0; wr_tid = 8'd0;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R12", "done", 32'(done), 1);
        expect_res("R12", 2'b10, 0, 32'h0123_4000, 2);
        lookup(32'h0001_2345, 2'd0, 1'b1, 8'd5, lat);
        expect_res("R12", 2'b00, 0, 32'h0, 0);

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule